// File: doc/BRIEF.md
# Line-Doubling Video Scan Converter

The block turns a 15 kHz video line stream into a 31 kHz progressive stream. Each line that arrives from the source timing generator is captured into one half of a two-line ping-pong memory. The line captured before it is played out of the other half twice. Everything runs on one master clock. The input side samples a pixel every fourth master clock. The output side walks its line at half the master rate, so exactly two output lines fit into one input line.

The output timing counter aligns itself once, at the first input hsync after reset, and then runs freely. Every output line is therefore exactly half an input line in master clocks. Later input hsyncs never re-phase it, so consecutive doubled lines carry identical hsync timing. The output hsync pulse lasts half of the measured input pulse. The output vsync starts and ends on output line boundaries and lasts a parameter number of output lines.

Top module: `line_doubler`

## Requirements
- R1: From reset until the first input hsync rising edge has been seen, pix_out, hs_out and vs_out stay 0.
- R2: Once locked, output lines repeat with a period of exactly LINE_CLKS/2 master clocks, counted from the clock that sampled the first input hsync high.
- R3: Input pixel k of a line is the pix_in value sampled 4k clocks after the clock that first samples hs_in high (k = 0 .. LINE_CLKS/4-1). During both output lines of pair n, output position c shows pixel c/2 (rounded down) of input line n-1. Output pair n starts at the same clock as input line n.
- R4: An output value for output position c appears on the ports two master clocks after the output counter holds c.
- R5: For output positions outside [ACT_BEG, ACT_END), pix_out is 0.
- R6: hs_out is high for the first W/2 (rounded down) clocks of every output line, where W is the number of clocks hs_in was last sampled high.
- R7: After a rising edge on vs_in, vs_out goes high at the start of the next output line and stays high for exactly VS_LINES output lines. Both of its edges fall on output line starts.
- R8: After locking, input hsyncs that arrive off the expected phase do not shift the output line timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | master clock |
| rst_n | input | 1 | active-low synchronous reset |
| pix_in | input | PIX_W | source pixel data |
| hs_in | input | 1 | source horizontal sync, active high |
| vs_in | input | 1 | source vertical sync, active high |
| pix_out | output | PIX_W | doubled-rate pixel data |
| hs_out | output | 1 | doubled-rate horizontal sync |
| vs_out | output | 1 | doubled-rate vertical sync |

## Verification
All three outputs lag the output position counter by two registers: one stage for the synchronous memory read and one output stage. The bench therefore compares the ports after clock m against a model evaluated for the counter state at clock m-2. The input side needs no extra delay, because a pixel is written on the same clock that samples it, and the bench places each input pixel exactly 4k clocks after the hsync clock. The vsync model predicts the first output line boundary at or after the vs_in edge, then counts VS_LINES line periods from that boundary.

// File: rtl/line_doubler.sv
module line_doubler #(
  parameter int PIX_W     = 6,
  parameter int LINE_CLKS = 3420,
  parameter int ACT_BEG   = 160,
  parameter int ACT_END   = 1600,
  parameter int VS_LINES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             hs_in,
  input  logic             vs_in,
  output logic [PIX_W-1:0] pix_out,
  output logic             hs_out,
  output logic             vs_out
);
  localparam int OUT_CLKS = LINE_CLKS / 2;
  localparam int PPL      = LINE_CLKS / 4;
  localparam int IW       = $clog2(PPL + 1);
  localparam int OW       = $clog2(OUT_CLKS);
  localparam int HW       = $clog2(LINE_CLKS + 1);
  localparam int VW       = $clog2(VS_LINES + 1);

  logic hs_d, vs_d;
  wire hs_rise = hs_in & ~hs_d;
  wire hs_fall = ~hs_in & hs_d;
  wire vs_rise = vs_in & ~vs_d;

  always_ff @(posedge clk)
    if (!rst_n) begin hs_d <= 1'b0; vs_d <= 1'b0; end
    else        begin hs_d <= hs_in; vs_d <= vs_in; end

  // capture side
  logic          wsel;
  logic [1:0]    ph;
  logic [IW-1:0] wcnt;
  wire           wr_line = hs_rise ? ~wsel : wsel;
  wire [IW-1:0]  wr_idx  = hs_rise ? '0 : wcnt;
  wire           wr_en   = hs_rise | (ph == 2'd0 && wcnt < IW'(PPL));

  always_ff @(posedge clk)
    if (!rst_n) begin
      wsel <= 1'b0; ph <= 2'd0; wcnt <= IW'(PPL);
    end else if (hs_rise) begin
      wsel <= ~wsel; ph <= 2'd1; wcnt <= IW'(1);
    end else begin
      ph <= ph + 2'd1;
      if (ph == 2'd0 && wcnt < IW'(PPL)) wcnt <= wcnt + IW'(1);
    end

  logic [PIX_W-1:0] mem [2**(IW+1)];
  logic [PIX_W-1:0] rdat;
  logic             rsel;
  logic [OW-1:0]    ocnt;
  wire  [IW-1:0]    rd_idx = IW'(ocnt >> 1);

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_line, wr_idx}] <= pix_in;
    rdat <= mem[{rsel, rd_idx}];
  end

  // input hsync width
  logic [HW-1:0] hcnt, hwid;
  always_ff @(posedge clk)
    if (!rst_n) begin hcnt <= '0; hwid <= '0; end
    else begin
      if (hs_in) hcnt <= (hcnt == '1) ? hcnt : hcnt + HW'(1);
      else       hcnt <= '0;
      if (hs_fall) hwid <= hcnt;
    end

  // output timing: locks once, then free-runs
  logic          locked, opar, vs_arm;
  logic [VW-1:0] vcnt;
  wire           wrap = locked && ocnt == OW'(OUT_CLKS - 1);

  always_ff @(posedge clk)
    if (!rst_n) begin
      locked <= 1'b0; ocnt <= '0; opar <= 1'b0; rsel <= 1'b0;
    end else if (!locked) begin
      if (hs_rise) begin
        locked <= 1'b1; ocnt <= '0; opar <= 1'b0; rsel <= wsel;
      end
    end else if (wrap) begin
      ocnt <= '0;
      opar <= ~opar;
      if (opar) rsel <= wsel;
    end else begin
      ocnt <= ocnt + OW'(1);
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      vs_arm <= 1'b0; vcnt <= '0;
    end else if (wrap) begin
      if (vs_arm || vs_rise) begin vcnt <= VW'(VS_LINES); vs_arm <= 1'b0; end
      else if (vcnt != '0) vcnt <= vcnt - VW'(1);
    end else if (vs_rise) begin
      vs_arm <= 1'b1;
    end

  wire [HW-1:0] half_w = hwid >> 1;
  wire act_raw = locked && ocnt >= OW'(ACT_BEG) && ocnt < OW'(ACT_END);
  wire hs_raw  = locked && (HW'(ocnt) < half_w);
  wire vs_raw  = vcnt != '0;

  logic act_q, hs_q, vs_q;
  always_ff @(posedge clk)
    if (!rst_n) begin
      act_q <= 1'b0; hs_q <= 1'b0; vs_q <= 1'b0;
      pix_out <= '0; hs_out <= 1'b0; vs_out <= 1'b0;
    end else begin
      act_q <= act_raw; hs_q <= hs_raw; vs_q <= vs_raw;
      pix_out <= act_q ? rdat : '0;
      hs_out <= hs_q; vs_out <= vs_q;
    end

  a_r1_quiet_before_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (pix_out == '0 && !hs_out && !vs_out));
  a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  a_r3_swap_on_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked) && rsel != $past(rsel)) |-> ocnt == '0);
  a_r6_hs_starts_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_raw) |-> ocnt == '0);
  a_r7_vs_edges_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_raw != $past(vs_raw)) |-> ocnt == '0);
endmodule

// File: tb/tb_line_doubler.sv
module tb_line_doubler;
  localparam int PIX_W = 6, LINE = 3420, HALF = LINE / 2, PPL = LINE / 4;
  localparam int ABEG = 160, AEND = 1600, VSL = 3, HWID = 252;
  localparam int BASE = 20, NLINES = 12, SHIFT_FROM = 10, SHIFT = 37;
  localparam int EV = BASE + 5 * LINE + 500;
  localparam int VW0 = BASE + 5 * LINE + HALF;
  localparam int LAST = BASE + NLINES * LINE + 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PIX_W-1:0] pix_in = '0;
  logic hs_in = 1'b0, vs_in = 1'b0;
  logic [PIX_W-1:0] pix_out;
  logic hs_out, vs_out;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  logic [PIX_W-1:0] pat [4][PPL];

  line_doubler #(.PIX_W(PIX_W), .LINE_CLKS(LINE), .ACT_BEG(ABEG), .ACT_END(AEND),
                 .VS_LINES(VSL)) dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input int t, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", req, t, act, exp);
    end
  endtask

  function automatic bit exp_vs(input int t);
    return t >= VW0 && t < VW0 + VSL * HALF;
  endfunction

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (5) @(negedge clk);
    chk("R1 reset pix", -1, pix_out, 0);
    chk("R1 reset hs", -1, hs_out, 0);
    chk("R1 reset vs", -1, vs_out, 0);
    for (int e = 0; e <= LAST; e++) begin
      @(negedge clk);
      rst_n = 1'b1;
      if (e >= 1) begin
        int t;
        t = e - 3;
        if (t < BASE) begin
          chk("R1 pix before lock", t, pix_out, 0);
          chk("R1 hs before lock", t, hs_out, 0);
          chk("R1 vs before lock", t, vs_out, 0);
        end else begin
          int rel, c, n, ep;
          bit eh;
          rel = t - BASE; c = rel % HALF; n = rel / LINE;
          eh = (t >= BASE + HWID) && (c < HWID / 2);
          chk(n >= SHIFT_FROM ? "R8 hs period after off-phase hsync" : "R2 R6 hs timing",
              t, hs_out, eh);
          chk("R7 vs", t, vs_out, exp_vs(t));
          if (n >= 1 && n < SHIFT_FROM) begin
            if (c >= ABEG && c < AEND) begin
              ep = pat[(n - 1) % 4][c >> 1];
              chk("R3 R4 doubled pixel", t, pix_out, ep);
            end else
              chk("R5 blank outside window", t, pix_out, 0);
          end
        end
      end
      begin
        int rel, n, j;
        pix_in = PIX_W'($urandom);
        hs_in = 1'b0;
        vs_in = (e >= EV && e < BASE + 7 * LINE);
        if (e >= BASE) begin
          rel = e - BASE;
          if (rel >= SHIFT_FROM * LINE) rel -= SHIFT;
          n = rel / LINE; j = rel % LINE;
          hs_in = j < HWID;
          if (n < SHIFT_FROM && j % 4 == 0) begin
            logic [PIX_W-1:0] v;
            v = PIX_W'($urandom);
            if (n == 3) v = '1;
            if (n == 4) v = ((j / 4) % 2 == 1) ? '1 : '0;
            pat[n % 4][j / 4] = v;
            pix_in = v;
          end
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 60000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule